// File: doc/BRIEF.md
# Circuit-Switched Source Wrapper

This block is the sending-side network interface of a pipelined circuit-switched on-chip network. A local core asks for a transfer by giving a destination address and a burst length. The wrapper then reserves an end-to-end circuit before it moves any data. It raises a one-bit request line toward the first switch and places a probe header holding the destination on the data lines. It then watches a two-bit answer code that comes back from the network.

When the network reports that the receiver is ready, the wrapper streams the core's data words onto the 16-bit path. A strobe wire marks each valid word. Once the circuit is open there is no per-word flow control. The only brake is a not-ready answer, which pauses the stream. If the network reports that every path is blocked, the wrapper drops the request for one cycle and probes again. It does this up to a retry limit, which the core gives with each transfer; after that it flags an error. When the last word has left, the wrapper drops the request to release the circuit and signals completion.

Answer codes on `net_ans`: 00 = probe still advancing, 01 = receiver ready, 10 = path blocked, 11 = receiver not ready.

Top module: `cs_src_wrapper`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `net_req`, `net_strobe`, `done` and `err` are 0, and `req_ready` is 1.
- R2: A request accepted in idle (`req_valid` and `req_ready` both 1 at a clock edge) makes `net_req` 1 from the next cycle. In that cycle `net_data` carries the destination, zero-extended into the low bits, and `net_strobe` is 0.
- R3: While probing, an answer of 00 or 11 keeps `net_req` at 1, with `wr_ready` and `net_strobe` at 0.
- R4: In any cycle where the answer is 01 and a circuit is being probed or is open, `wr_ready` is 1 in that same cycle. If `wr_valid` is also 1, then `net_strobe` is 1 and `net_data` equals `wr_data`, with no wait cycle after the first 01.
- R5: During transmission, an answer of 11 holds `net_req` at 1 and forces `wr_ready` and `net_strobe` to 0.
- R6: Exactly `req_len`+1 words are sent. In the cycle after the last word, `net_req` is 0 and `done` is 1 for one cycle. Then the wrapper is idle again.
- R7: An answer of 10 while probing, with retries left, makes `net_req` 0 for exactly one cycle. The probe then starts again with `net_req` at 1.
- R8: An answer of 10 after `max_retry` retries have been used makes `err` 1 for one cycle, with `net_req` 0, and the wrapper returns to idle. With `max_retry` = 0, the first 10 ends the transfer this way.
- R9: `req_ready` is 1 only while idle. A `req_valid` during a transfer is not accepted, and the destination header stays unchanged.
- R10: During transmission, a cycle with `wr_valid` at 0 sends nothing: `net_strobe` is 0 and the cycle does not count toward the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Wrapper can take a transfer (idle) |
| req_dest | input | 4 | Destination address |
| req_len | input | 6 | Burst length minus one |
| max_retry | input | 3 | Blocked-path retries allowed for this transfer |
| wr_valid | input | 1 | Core offers a data word |
| wr_ready | output | 1 | Wrapper takes the data word this cycle |
| wr_data | input | 16 | Data word from the core |
| net_req | output | 1 | Circuit request line to the first switch |
| net_data | output | 16 | Probe header or data word toward the network |
| net_strobe | output | 1 | Source strobe, marks a valid data word |
| net_ans | input | 2 | Answer code from the first switch |
| done | output | 1 | One-cycle pulse: transfer finished, circuit released |
| err | output | 1 | One-cycle pulse: retries used up, transfer abandoned |

## Verification
The assertions assume that the network answers 10 only while a probe is in flight, never once data has started. They also assume that the core keeps `req_valid` low when the wrapper is about to go idle, unless it means to start a new transfer. The bench drives 10 only in probe cycles, and it drops `req_valid` before the last word of every transfer. A table of transfers mixes burst lengths, retry limits, blocked counts above and below the limit, not-ready pauses and core-side gaps. Directed tests then cover reset, a reset in the middle of a burst, and a request offered while busy.

// File: rtl/cs_wrap_pkg.sv
// Shared types for the circuit-switched source wrapper.
// Assumes: the answer encodings below match the first switch.
package cs_wrap_pkg;

    typedef enum logic [1:0] {
        ANS_ADVANCE = 2'b00,
        ANS_GO      = 2'b01,
        ANS_BLOCKED = 2'b10,
        ANS_BUSY    = 2'b11
    } ans_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_GAP,
        ST_STREAM
    } wrap_state_e;

endpackage

// File: rtl/cs_ans_decode.sv
// Decodes the two-bit answer code from the network into flags.
// Assumes: the code is sampled in the same cycle it is used.
module cs_ans_decode
    import cs_wrap_pkg::*;
(
    input  logic [1:0] code,
    output logic       go,
    output logic       blocked
);

    // Flag the two codes that change wrapper behaviour.
    always_comb begin
        go      = (code == ANS_GO);
        blocked = (code == ANS_BLOCKED);
    end

endmodule

// File: rtl/cs_beat_ctr.sv
// Counts words sent in a burst and flags the final one.
// Assumes: load and step never occur in the same cycle.
module cs_beat_ctr #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;

    // Hold burst length and count words already sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            len_q <= load_len;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The current word is the last when the count reaches the length.
    always_comb last = (cnt_q == len_q);

endmodule

// File: rtl/cs_retry_ctr.sv
// Tracks how many blocked-path retries remain for a transfer.
// Assumes: dec is only raised while retries remain.
module cs_retry_ctr #(
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RETRY_W-1:0] load_val,
    input  logic               dec,
    output logic               exhausted
);

    logic [RETRY_W-1:0] left_q;

    // Load the limit at accept, count down per retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    // No retries remain once the count hits zero.
    always_comb exhausted = (left_q == '0);

endmodule

// File: rtl/cs_src_wrapper.sv
// Source-side wrapper: probes for a circuit, streams a burst, releases.
// Assumes: DATA_W > ADDR_W; the network sends 10 only while probing;
// an answer of 00 or 10 during streaming is treated as a pause.
module cs_src_wrapper
    import cs_wrap_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 6,
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_dest,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [RETRY_W-1:0] max_retry,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               net_req,
    output logic [DATA_W-1:0]  net_data,
    output logic               net_strobe,
    input  logic [1:0]         net_ans,
    output logic               done,
    output logic               err
);

    localparam int PAD_W = DATA_W - ADDR_W;

    wrap_state_e       state_q, state_d;
    logic [ADDR_W-1:0] dest_q;
    logic              done_q, err_q;
    logic              ans_go, ans_blocked;
    logic              accept, active, send, last_word;
    logic              retries_out, give_up, retry;
    logic [DATA_W-1:0] probe_hdr;

    cs_ans_decode u_dec (
        .code    (net_ans),
        .go      (ans_go),
        .blocked (ans_blocked)
    );

    cs_beat_ctr #(.LEN_W(LEN_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_len (req_len),
        .step     (send),
        .last     (last_word)
    );

    cs_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (max_retry),
        .dec       (retry),
        .exhausted (retries_out)
    );

    // Handshake and data-path controls derived from state and answer.
    always_comb begin
        active    = (state_q == ST_PROBE) || (state_q == ST_STREAM);
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        wr_ready  = active && ans_go;
        send      = wr_ready && wr_valid;
        give_up   = (state_q == ST_PROBE) && ans_blocked && retries_out;
        retry     = (state_q == ST_PROBE) && ans_blocked && !retries_out;
        probe_hdr = {{PAD_W{1'b0}}, dest_q};
    end

    // Next-state selection for setup, transmission and release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PROBE;
            ST_PROBE: begin
                if (ans_go) begin
                    state_d = (send && last_word) ? ST_IDLE : ST_STREAM;
                end else if (give_up) begin
                    state_d = ST_IDLE;
                end else if (retry) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP:    state_d = ST_PROBE;
            ST_STREAM: if (send && last_word) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register, latched destination and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dest_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) dest_q <= req_dest;
            done_q  <= send && last_word;
            err_q   <= give_up;
        end
    end

    // Network-side outputs: request line, strobe and data mux.
    always_comb begin
        net_req    = active;
        net_strobe = send;
        if (send) begin
            net_data = wr_data;
        end else if (state_q == ST_PROBE) begin
            net_data = probe_hdr;
        end else begin
            net_data = '0;
        end
        done = done_q;
        err  = err_q;
    end

endmodule

// File: rtl/cs_src_wrapper_chk.sv
// Port-level temporal checks for the source wrapper, bound to the top.
// Assumes: answer 10 arrives only while probing.
module cs_src_wrapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       net_req,
    input logic       net_strobe,
    input logic [1:0] net_ans,
    input logic       done,
    input logic       err
);

    // R2: an accepted request raises the circuit request next cycle.
    a_r2_accept_probes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> net_req && !req_ready);

    // R9: no new request is taken while a circuit is held.
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        net_req |-> !req_ready);

    // R4: a word is strobed only on a ready answer with core data present.
    a_r4_strobe_on_go: assert property (@(posedge clk) disable iff (!rst_n)
        net_strobe |-> net_req && net_ans == 2'b01 && wr_valid && wr_ready);

    // R5: not-ready pauses data while the request is held.
    a_r5_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        net_req && net_ans == 2'b11 |-> !net_strobe && !wr_ready);

    // R6: done follows a sent word, with the circuit released, for one cycle.
    a_r6_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !net_req && $past(net_strobe));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: error follows a blocked answer during a held request.
    a_r8_err_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !net_req && $past(net_req) && $past(net_ans) == 2'b10);

endmodule

bind cs_src_wrapper cs_src_wrapper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .net_req    (net_req),
    .net_strobe (net_strobe),
    .net_ans    (net_ans),
    .done       (done),
    .err        (err)
);

// File: tb/cs_src_wrapper_tb.sv
module cs_src_wrapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_dest = '0;
    logic [5:0]  req_len = '0;
    logic [2:0]  max_retry = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_data = '0;
    logic        net_req;
    logic [15:0] net_data;
    logic        net_strobe;
    logic [1:0]  net_ans = 2'b00;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam int NV = 6;
    localparam int V_DEST  [NV] = '{3, 9, 15, 0, 6, 12};
    localparam int V_LEN   [NV] = '{0, 3, 7, 2, 4, 1};
    localparam int V_MAXR  [NV] = '{0, 2, 1, 3, 0, 2};
    localparam int V_NBLK  [NV] = '{0, 1, 2, 3, 1, 2};
    localparam int V_STALL [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int V_GAP   [NV] = '{0, 0, 1, 1, 0, 1};

    cs_src_wrapper u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_len(req_len), .max_retry(max_retry),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .net_req(net_req), .net_data(net_data), .net_strobe(net_strobe),
        .net_ans(net_ans), .done(done), .err(err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int v, input int k);
        return 16'(32'hA000 ^ (v * 32'h0111) ^ (k * 13));
    endfunction

    task automatic run_txn(input int v, input int dest, input int len, input int maxr,
                           input int nblk, input int stall, input int gap);
        int k;
        int cyc;
        @(negedge clk);
        req_valid = 1'b1; req_dest = 4'(dest); req_len = 6'(len);
        max_retry = 3'(maxr); net_ans = 2'b00; wr_valid = 1'b0;
        #1 chk(req_ready == 1'b1, "R9 ready while idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(net_req == 1'b1, "R2 request raised", int'(net_req), 1);
        chk(net_data == 16'(dest), "R2 header carries destination", int'(net_data), dest);
        chk(net_strobe == 1'b0, "R2 no strobe on header", int'(net_strobe), 0);
        chk(wr_ready == 1'b0, "R3 advancing holds data", int'(wr_ready), 0);
        @(negedge clk);
        net_ans = 2'b11;
        #1 chk(net_req && !net_strobe && !wr_ready, "R3 not-ready while probing",
               int'({net_req, net_strobe, wr_ready}), 4);
        for (int b = 0; b < nblk; b++) begin
            @(negedge clk);
            net_ans = 2'b10;
            @(negedge clk);
            net_ans = 2'b00;
            #1;
            if (b < maxr) begin
                chk(net_req == 1'b0, "R7 request dropped one cycle", int'(net_req), 0);
                @(negedge clk);
                #1 chk(net_req == 1'b1, "R7 probe restarts", int'(net_req), 1);
            end else begin
                chk(err == 1'b1 && net_req == 1'b0, "R8 error after retries",
                    int'({err, net_req}), 2);
                @(negedge clk);
                #1 chk(err == 1'b0 && req_ready == 1'b1, "R8 error single cycle, idle",
                       int'({err, req_ready}), 1);
                return;
            end
        end
        k = 0;
        cyc = 0;
        while (k <= len) begin
            @(negedge clk);
            if (stall != 0 && cyc % 3 == 1) begin
                net_ans = 2'b11; wr_valid = 1'b1; wr_data = pat(v, k);
                #1 chk(!net_strobe && !wr_ready && net_req, "R5 stall in stream",
                       int'({net_strobe, wr_ready, net_req}), 1);
            end else if (gap != 0 && cyc % 3 == 2) begin
                net_ans = 2'b01; wr_valid = 1'b0;
                #1 chk(net_strobe == 1'b0, "R10 empty cycle not sent", int'(net_strobe), 0);
            end else begin
                net_ans = 2'b01; wr_valid = 1'b1; wr_data = pat(v, k);
                #1;
                chk(wr_ready && net_strobe, "R4 word sent on ready answer",
                    int'({wr_ready, net_strobe}), 3);
                chk(net_data == pat(v, k), "R4 data passes through",
                    int'(net_data), int'(pat(v, k)));
                chk(done == 1'b0, "R6 no early done", int'(done), 0);
                k++;
            end
            cyc++;
        end
        @(negedge clk);
        wr_valid = 1'b0; net_ans = 2'b00;
        #1 chk(done == 1'b1 && net_req == 1'b0, "R6 release and done",
               int'({done, net_req}), 2);
        @(negedge clk);
        #1 chk(done == 1'b0 && req_ready == 1'b1, "R6 done single cycle, idle",
               int'({done, req_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!net_req && !net_strobe && !done && !err, "R1 outputs low in reset",
            int'({net_req, net_strobe, done, err}), 0);
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(!net_req && req_ready && !done && !err, "R1 idle after reset",
               int'({net_req, req_ready, done, err}), 4);

        for (int v = 0; v < NV; v++) begin
            run_txn(v, V_DEST[v], V_LEN[v], V_MAXR[v], V_NBLK[v], V_STALL[v], V_GAP[v]);
        end

        // R9: a second request while busy is refused and the header is kept.
        @(negedge clk);
        req_valid = 1'b1; req_dest = 4'd5; req_len = 6'd1; max_retry = 3'd0;
        @(negedge clk);
        req_dest = 4'd10;
        #1 chk(req_ready == 1'b0, "R9 not ready while busy", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1 chk(net_data == 16'd5, "R9 header unchanged", int'(net_data), 5);
        net_ans = 2'b01; wr_valid = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_data = 16'h5678;
        #1 chk(net_data == 16'h5678 && net_strobe, "R4 second word", int'(net_data), 16'h5678);
        @(negedge clk);
        wr_valid = 1'b0; net_ans = 2'b00;
        #1 chk(done == 1'b1, "R6 two-word burst done", int'(done), 1);

        // R1: reset in the middle of a burst returns to idle.
        @(negedge clk);
        req_valid = 1'b1; req_dest = 4'd7; req_len = 6'd9; max_retry = 3'd1;
        @(negedge clk);
        req_valid = 1'b0; net_ans = 2'b01; wr_valid = 1'b1; wr_data = 16'hBEEF;
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; net_ans = 2'b00;
        @(negedge clk);
        #1 chk(!net_req && req_ready && !done && !err, "R1 reset mid-burst",
               int'({net_req, req_ready, done, err}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(!net_req && !net_strobe, "R1 idle after mid-burst reset",
               int'({net_req, net_strobe}), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule